// File: doc/BRIEF.md
# Instruction-Level Power Estimator

This block sits beside a 16-bit fixed-point DSP core and watches the stream of retired instructions. For each accepted instruction it derives a current estimate from the data the instruction carries. The sources are the zero bits driven onto precharged buses, a sign-extension cost, the toggling of the functional unit's output, a penalty when the instruction differs from its predecessor, and the extra current drawn from the X or Y data memory bank. Each instruction's current, weighted by its cycle count, is summed into a saturating energy accumulator.

Each instruction carries a class code, a flag that says whether the operands came from data/address registers or from accumulators, the 16-bit input operand, the 16-bit output the unit produced, a memory-bank tag and a cycle count. The block keeps the previous class, source flag and output, so it can find output toggles and class transitions. In a cycle with no instruction, only an idle constant is accumulated. Every weight is a 16-bit register loaded through a write port. This lets one netlist be calibrated against measured silicon.

Top module: `instr_power_est`

## Requirements
- R1: After reset, and one cycle after `clr_i` is high, `energy_o` and `cur_o` are 0. While `clr_i` is high, `in_ready_o` is low. `in_ready_o` is high otherwise. A clear also drops the instruction history: the next instruction pays no overhead and its output toggles are counted against 0.
- R2: An instruction is accepted when `in_valid_i` and `in_ready_o` are both high. At the next rising edge, `cur_o` shows its current: class constant + precharge term + switching term + overhead + memory term. Class codes are 0 ALU, 1 MPU (multiply and multiply-accumulate alike), 2 MOV and 3 other.
- R3: For classes ALU, MOV and other, the precharge term applies only when `in_regsrc_i` is 1. It is then the number of zero bits in the operand times the bus-unit weight, plus the sign-extension weight when operand bit 15 is 0. When `in_regsrc_i` is 0, the precharge term is 0.
- R4: For class MPU with `in_regsrc_i` at 1, the precharge term is the sum, over operand bits 3:0, 7:4, 11:8 and 15:12, of each slice's zero count times that slice's weight. No sign-extension term is added.
- R5: The switching term is the number of toggled bits among bits 14:0 of `result XOR previous result`, times the switch weight. A toggle on bit 15 adds a further amount: the switch weight for ALU and other, five times the switch weight for MPU, and the MOV sign weight for MOV.
- R6: An instruction pays overhead when a previous instruction exists and either the class or the source flag differs from that instruction. The overhead is pair-table entry [4*previous class + current class] plus the overhead-precharge weight. Otherwise the overhead is 0.
- R7: Bank tag 1 (X) adds (memory-idle weight * 15) >> 8. Bank tag 2 (Y) adds (memory-idle weight * 37) >> 8. Tags 0 and 3 add nothing.
- R8: An accepted instruction adds `cur * in_cycles_i` to `energy_o` at the same edge that updates `cur_o`. A cycle count of 0 adds nothing.
- R9: In a cycle with no accepted instruction and no clear, `cur_o` becomes the idle weight and `energy_o` grows by it. The stored previous class, source flag and output stay unchanged.
- R10: `energy_o` saturates at all ones and stays there until a clear.
- R11: A write with `cfg_we_i` high stores `cfg_wdata_i` at `cfg_addr_i`, and the new value is used from the next cycle on. The map is:
  - 0–3: class constant, by class code
  - 4: bus unit
  - 5: sign extension
  - 6–9: slice weights, slice 0 (bits 3:0) to slice 3 (bits 15:12)
  - 10: switch weight
  - 11: MOV sign weight
  - 12: overhead precharge
  - 13: idle
  - 14: memory idle
  - 16–31: pair table

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of energy, current and history |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_addr_i | input | 5 | Coefficient address |
| cfg_wdata_i | input | COEF_W (16) | Coefficient value |
| in_valid_i | input | 1 | Instruction present |
| in_ready_o | output | 1 | Instruction can be taken |
| in_class_i | input | 2 | Class code |
| in_regsrc_i | input | 1 | 1: operands from data/address registers |
| in_opnd_i | input | 16 | Input operand |
| in_result_i | input | 16 | Output value of the unit |
| in_bank_i | input | 2 | Memory bank tag |
| in_cycles_i | input | CYC_W (4) | Cycle count |
| cur_o | output | CUR_W (24) | Current of the last cycle |
| energy_o | output | ACC_W (48) | Accumulated energy |

## Verification
The bench aims at the data-dependent corners of the model:
- an operand with bit 15 at 0 against one with it set, which a design with the sign-extension test inverted would miss;
- accumulator-sourced operands, where a leaky precharge mux would still charge;
- an MPU sign toggle, which must cost five units;
- a same-class pair that differs only in its source flag, which must still pay overhead.

An idle cycle between instructions shows whether the history is kept; a design that wipes it would report extra toggles. A zero cycle count must leave the energy untouched. A long run of heavy instructions must pin the accumulator at all ones rather than let it wrap to a small value.

// File: rtl/ipe_pkg.sv
package ipe_pkg;
  localparam int DW     = 16;
  localparam int NCOEF  = 32;
  localparam int CAW    = $clog2(NCOEF);

  typedef enum logic [1:0] {CL_ALU = 2'd0, CL_MPU = 2'd1, CL_MOV = 2'd2, CL_OTH = 2'd3} cls_e;

  localparam int A_BUS   = 4;
  localparam int A_SEXT  = 5;
  localparam int A_SLC0  = 6;
  localparam int A_SW    = 10;
  localparam int A_MOVSG = 11;
  localparam int A_OVPRE = 12;
  localparam int A_IDLE  = 13;
  localparam int A_IMEM  = 14;
  localparam int A_PAIR  = 16;

  localparam int MEM_X_NUM = 15;
  localparam int MEM_Y_NUM = 37;
  localparam int MEM_SHIFT = 8;

  function automatic logic [4:0] ones16(input logic [15:0] v);
    logic [4:0] n;
    n = '0;
    for (int i = 0; i < 16; i++) n = n + 5'(v[i]);
    return n;
  endfunction

  function automatic logic [2:0] ones4(input logic [3:0] v);
    logic [2:0] n;
    n = '0;
    for (int i = 0; i < 4; i++) n = n + 3'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/ipe_coef_regs.sv
module ipe_coef_regs
  import ipe_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CAW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  coef_o [NCOEF]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCOEF; i++) coef_o[i] <= '0;
    end else if (we_i) begin
      coef_o[addr_i] <= wdata_i;
    end
  end

  a_r11_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> coef_o[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/ipe_base_cost.sv
module ipe_base_cost
  import ipe_pkg::*;
#(
  parameter int CW = 16,
  parameter int OW = 24
) (
  input  logic [1:0]    cls_i,
  input  logic          src_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] tog_i,
  input  logic [CW-1:0] coef_i [NCOEF],
  output logic [OW-1:0] base_o
);
  localparam int NSLC = DW / 4;

  logic [DW-1:0] zeros;
  logic [OW-1:0] slice_t [NSLC];
  logic [OW-1:0] flat_pre, mpu_pre, pre, sw_low, sign_w, sw;

  assign zeros = ~opnd_i;

  for (genvar s = 0; s < NSLC; s++) begin : g_slc
    assign slice_t[s] = OW'(ones4(zeros[4*s +: 4])) * OW'(coef_i[A_SLC0 + s]);
  end

  always_comb begin
    mpu_pre = '0;
    for (int s = 0; s < NSLC; s++) mpu_pre = mpu_pre + slice_t[s];
    flat_pre = OW'(ones16(zeros)) * OW'(coef_i[A_BUS])
             + (opnd_i[DW-1] ? '0 : OW'(coef_i[A_SEXT]));
    if (!src_i)              pre = '0;
    else if (cls_i == CL_MPU) pre = mpu_pre;
    else                      pre = flat_pre;

    sw_low = OW'(ones16({1'b0, tog_i[DW-2:0]})) * OW'(coef_i[A_SW]);
    case (cls_i)
      CL_MPU:  sign_w = OW'(coef_i[A_SW]) * OW'(5);
      CL_MOV:  sign_w = OW'(coef_i[A_MOVSG]);
      default: sign_w = OW'(coef_i[A_SW]);
    endcase
    sw = sw_low + (tog_i[DW-1] ? sign_w : '0);

    base_o = OW'(coef_i[cls_i]) + pre + sw;
  end

  always_comb begin
    a_r3_acc_no_pre: assert (src_i || pre == '0);
    a_r5_no_tog_no_sw: assert (tog_i != '0 || sw == '0);
  end
endmodule

// File: rtl/ipe_overhead.sv
module ipe_overhead
  import ipe_pkg::*;
#(
  parameter int CW = 16,
  parameter int OW = 24
) (
  input  logic          prev_vld_i,
  input  logic [1:0]    prev_cls_i,
  input  logic          prev_src_i,
  input  logic [1:0]    cls_i,
  input  logic          src_i,
  input  logic [CW-1:0] coef_i [NCOEF],
  output logic [OW-1:0] ov_o
);
  logic           hit;
  logic [CAW-1:0] idx;

  assign hit = prev_vld_i && ((prev_cls_i != cls_i) || (prev_src_i != src_i));
  assign idx = CAW'(A_PAIR) + CAW'({prev_cls_i, cls_i});
  assign ov_o = hit ? OW'(coef_i[idx]) + OW'(coef_i[A_OVPRE]) : '0;

  always_comb begin
    a_r6_first_free: assert (prev_vld_i || ov_o == '0);
  end
endmodule

// File: rtl/instr_power_est.sv
module instr_power_est
  import ipe_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int CYC_W  = 4,
  parameter int ACC_W  = 48,
  localparam int CUR_W = COEF_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cfg_we_i,
  input  logic [4:0]        cfg_addr_i,
  input  logic [COEF_W-1:0] cfg_wdata_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_class_i,
  input  logic              in_regsrc_i,
  input  logic [15:0]       in_opnd_i,
  input  logic [15:0]       in_result_i,
  input  logic [1:0]        in_bank_i,
  input  logic [CYC_W-1:0]  in_cycles_i,
  output logic [CUR_W-1:0]  cur_o,
  output logic [ACC_W-1:0]  energy_o
);
  localparam int IW = CUR_W + CYC_W;

  logic [COEF_W-1:0] coef [NCOEF];
  logic              acc;
  logic              prev_vld_q, prev_src_q;
  logic [1:0]        prev_cls_q;
  logic [DW-1:0]     prev_res_q;
  logic [CUR_W-1:0]  base, ov, mem, cur_next;
  logic [IW-1:0]     incr;
  logic [ACC_W:0]    sum;
  logic [ACC_W-1:0]  energy_next;

  ipe_coef_regs #(.W(COEF_W)) u_coef (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .coef_o(coef)
  );

  ipe_base_cost #(.CW(COEF_W), .OW(CUR_W)) u_base (
    .cls_i(in_class_i), .src_i(in_regsrc_i), .opnd_i(in_opnd_i),
    .tog_i(in_result_i ^ prev_res_q), .coef_i(coef), .base_o(base)
  );

  ipe_overhead #(.CW(COEF_W), .OW(CUR_W)) u_ov (
    .prev_vld_i(prev_vld_q), .prev_cls_i(prev_cls_q), .prev_src_i(prev_src_q),
    .cls_i(in_class_i), .src_i(in_regsrc_i), .coef_i(coef), .ov_o(ov)
  );

  assign in_ready_o = !clr_i;
  assign acc        = in_valid_i && in_ready_o;

  always_comb begin
    case (in_bank_i)
      2'd1:    mem = (CUR_W'(coef[A_IMEM]) * CUR_W'(MEM_X_NUM)) >> MEM_SHIFT;
      2'd2:    mem = (CUR_W'(coef[A_IMEM]) * CUR_W'(MEM_Y_NUM)) >> MEM_SHIFT;
      default: mem = '0;
    endcase
    cur_next    = acc ? base + ov + mem : CUR_W'(coef[A_IDLE]);
    incr        = acc ? IW'(cur_next) * IW'(in_cycles_i) : IW'(cur_next);
    sum         = (ACC_W+1)'(energy_o) + (ACC_W+1)'(incr);
    energy_next = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      energy_o   <= '0;
      cur_o      <= '0;
      prev_vld_q <= 1'b0;
      prev_cls_q <= '0;
      prev_src_q <= 1'b0;
      prev_res_q <= '0;
    end else if (clr_i) begin
      energy_o   <= '0;
      cur_o      <= '0;
      prev_vld_q <= 1'b0;
      prev_cls_q <= '0;
      prev_src_q <= 1'b0;
      prev_res_q <= '0;
    end else begin
      energy_o <= energy_next;
      cur_o    <= cur_next;
      if (acc) begin
        prev_vld_q <= 1'b1;
        prev_cls_q <= in_class_i;
        prev_src_q <= in_regsrc_i;
        prev_res_q <= in_result_i;
      end
    end
  end

  a_r1_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (energy_o == '0) && (cur_o == '0) && !prev_vld_q);
  a_r8_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> energy_o >= $past(energy_o));
  a_r10_sat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (energy_o == '1) && !clr_i |=> energy_o == '1);
  a_r9_idle_keeps_prev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i && !clr_i |=> (prev_cls_q == $past(prev_cls_q)) &&
                              (prev_src_q == $past(prev_src_q)) &&
                              (prev_res_q == $past(prev_res_q)));
endmodule

// File: tb/instr_power_est_bench.sv
`timescale 1ns/1ps
module instr_power_est_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_class = '0;
  logic        in_regsrc = 1'b0;
  logic [15:0] in_opnd = '0;
  logic [15:0] in_result = '0;
  logic [1:0]  in_bank = '0;
  logic [3:0]  in_cycles = '0;
  logic [23:0] cur;
  logic [31:0] energy;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  instr_power_est #(.COEF_W(16), .CYC_W(4), .ACC_W(32)) u_instr_power_est (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_class_i(in_class),
    .in_regsrc_i(in_regsrc), .in_opnd_i(in_opnd), .in_result_i(in_result),
    .in_bank_i(in_bank), .in_cycles_i(in_cycles), .cur_o(cur), .energy_o(energy)
  );

  typedef struct packed {
    logic [1:0]  cls;
    logic        src;
    logic [15:0] op;
    logic [15:0] res;
    logic [1:0]  bk;
    logic [3:0]  cyc;
    logic [23:0] cur;
    logic [31:0] en;
  } vec_t;

  // Coefficients: class 100/200/300/50, bus 2, sext 40, slices 1..4, sw 3,
  // mov sign 11, ov pre 7, idle 9, mem idle 256, pair[p][c] = 20+10p+c
  localparam vec_t TBL [8] = '{
    '{2'd0, 1'b1, 16'h00FF, 16'h0003, 2'd0, 4'd1, 24'd162, 32'd162},  // R3 R2
    '{2'd0, 1'b1, 16'h8000, 16'h8003, 2'd1, 4'd2, 24'd148, 32'd458},  // R3 R7 R8
    '{2'd1, 1'b1, 16'h0F0F, 16'h0F03, 2'd2, 4'd1, 24'd316, 32'd774},  // R4 R5 R6 R7
    '{2'd2, 1'b0, 16'h0000, 16'h0F03, 2'd0, 4'd1, 24'd339, 32'd1113}, // R3 R6
    '{2'd2, 1'b1, 16'h7FFF, 16'h8F03, 2'd0, 4'd3, 24'd402, 32'd2319}, // R5 R6
    '{2'd3, 1'b0, 16'hFFFF, 16'h8F02, 2'd0, 4'd1, 24'd103, 32'd2422}, // R5 R6
    '{2'd1, 1'b0, 16'h0000, 16'h0F02, 2'd0, 4'd0, 24'd273, 32'd2422}, // R4 R8
    '{2'd0, 1'b1, 16'hFFFF, 16'h0F02, 2'd0, 4'd1, 24'd137, 32'd2559}  // R3 R6
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [1:0] c, input logic s, input logic [15:0] op,
                      input logic [15:0] r, input logic [1:0] b, input logic [3:0] n);
    in_valid = 1'b1; in_class = c; in_regsrc = s; in_opnd = op;
    in_result = r; in_bank = b; in_cycles = n;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_clr();
    clr = 1'b1;
    #1 check("R1 ready low in clear", 64'(in_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset energy", 64'(energy), 64'd0);
    check("R1 reset cur", 64'(cur), 64'd0);
    check("R1 reset ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    wr(0, 100); wr(1, 200); wr(2, 300); wr(3, 50);
    wr(4, 2); wr(5, 40);
    for (int s = 0; s < 4; s++) wr(6 + s, s + 1);
    wr(10, 3); wr(11, 11); wr(12, 7); wr(13, 9); wr(14, 256);
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 4; c++) wr(16 + 4*p + c, 20 + 10*p + c);

    do_clr();
    check("R1 clear energy", 64'(energy), 64'd0);
    check("R1 clear cur", 64'(cur), 64'd0);

    for (int i = 0; i < 8; i++) begin
      send(TBL[i].cls, TBL[i].src, TBL[i].op, TBL[i].res, TBL[i].bk, TBL[i].cyc);
      check($sformatf("R2 vector %0d cur", i), 64'(cur), 64'(TBL[i].cur));
      check($sformatf("R8 vector %0d energy", i), 64'(energy), 64'(TBL[i].en));
    end

    idle();
    check("R9 idle cur", 64'(cur), 64'd9);
    check("R9 idle energy", 64'(energy), 64'd2568);
    // history kept: prev ALU/src1/0x0F02 -> src change pays pair[0][0]+7, no toggles
    send(2'd0, 1'b0, 16'h0000, 16'h0F02, 2'd0, 4'd1);
    check("R9 history after idle", 64'(cur), 64'd127);
    check("R6 source-only change energy", 64'(energy), 64'd2695);

    wr(0, 1000);
    send(2'd0, 1'b0, 16'h0000, 16'h0F02, 2'd0, 4'd1);
    check("R11 new class constant", 64'(cur), 64'd1000);

    do_clr();
    send(2'd2, 1'b0, 16'h0000, 16'h0F02, 2'd0, 4'd1);
    check("R1 history dropped by clear", 64'(cur), 64'd315);
    check("R1 energy restarts", 64'(energy), 64'd315);
    send(2'd2, 1'b0, 16'h0000, 16'h0F02, 2'd3, 4'd1);
    check("R7 bank tag 3 adds nothing", 64'(cur), 64'd300);

    wr(3, 65535); wr(4, 65535); wr(5, 65535);
    for (int k = 0; k < 300; k++) send(2'd3, 1'b1, 16'h0000, 16'h0F02, 2'd0, 4'd15);
    check("R10 saturated", 64'(energy), 64'hFFFF_FFFF);
    idle();
    check("R10 stays saturated", 64'(energy), 64'hFFFF_FFFF);
    do_clr();
    check("R1 clear after saturation", 64'(energy), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule